// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

The block watches over software by demanding a two-byte key, first A5h and then 5Ah, written to its protect register. If the key does not arrive often enough, the block sends a one-cycle reset pulse to the rest of the system. A free-running time-base counter sets the timing. A 2-bit interval code picks one of four adjacent high bits of that counter. The block counts the falling edges of the chosen bit. One edge with no service arms an edge flag. A second edge with the flag still set fires the reset.

The watchdog starts disarmed. Asserting the enable input turns it on, and only the block's reset input can turn it off again. The interval code is sampled while the watchdog is off and is then frozen. Five hold-off inputs stop a reset from building up. They cover sleep or stop, a DMA transfer, a debugger break, the interrupt-enable instruction and a step-trace trap. While any of them is asserted, the edge flag is cleared on every cycle. A clock-halving input makes the counter advance on every second clock instead of on every clock.

Top module: `keyed_watchdog`

## Requirements
- R1: The time-base counter starts at 0 when reset is released, or after a reset pulse. When `half_rate` is 0 it advances by one on every clock. When `half_rate` is 1 it advances on every second clock, and the first clock after a restart does not advance it. Interval code k (0 to 3) selects counter bit TAP_BASE+k. That bit falls once every P = 2^(TAP_BASE+k+1) counts.
- R2: Take a watchdog that is enabled and never serviced. Its first reset pulse comes exactly 2P+1 clocks after reset release when `half_rate` is 0, and 4P+1 clocks after release when `half_rate` is 1.
- R3: `wdt_reset` is high for exactly one clock. The pulse also clears the counter, the edge flag and the key state, so the next unserviced timeout is the same length as the first.
- R4: While the watchdog is not enabled, `wdt_reset` never rises. Once `wd_enable` has been seen high, the watchdog stays enabled after `wd_enable` falls, until `rst_n` is asserted.
- R5: The interval code is ignored once the watchdog is enabled. A change to it after enabling does not change the timeout.
- R6: A write of A5h followed by a write of 5Ah is a valid service and clears the edge flag. Any number of clocks may pass between the two writes. Servicing more often than every P counts prevents every reset.
- R7: A write of any byte other than A5h or 5Ah after an A5h cancels that A5h. A 5Ah that follows does not service the watchdog.
- R8: A 5Ah write with no A5h since the previous 5Ah has no effect. A 5Ah write with no A5h at all also has no effect.
- R9: A second A5h written after a first A5h keeps the key valid, and a following 5Ah still services the watchdog.
- R10: Each of `hold_sleep`, `hold_dma`, `hold_break`, `hold_inte` and `hold_trace` prevents any reset while it is high. Once it is released, the normal timeout resumes.
- R11: An A5h written before a reset pulse does not survive the pulse. A 5Ah written after the pulse with no new A5h has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle strobe for a write to the protect register |
| wr_data | input | 8 | Byte written to the protect register |
| wd_enable | input | 1 | Turns the watchdog on; one-way |
| interval | input | 2 | Tap select code k, frozen once the watchdog is enabled |
| half_rate | input | 1 | 1: the counter advances on every second clock |
| hold_sleep | input | 1 | Hold-off while in sleep or stop state |
| hold_dma | input | 1 | Hold-off during a DMA transfer |
| hold_break | input | 1 | Hold-off during a debugger break |
| hold_inte | input | 1 | Hold-off while the interrupt-enable instruction runs |
| hold_trace | input | 1 | Hold-off during a step-trace trap |
| wdt_reset | output | 1 | One-cycle reset pulse |

## Verification
The timeout is swept over all four interval codes at both counter rates, on a small counter. It is measured once from reset release and once from pulse to pulse. An error in the tap index, in the rate divider or in the clearing done by the pulse shows up as a cycle count that differs from 2P+1 or 4P+1.

Several key patterns are placed against a known falling-edge schedule:
- A5h then 5Ah.
- A5h, then a wrong byte, then 5Ah.
- 5Ah alone.
- Two 5Ah writes with no A5h between them.
- A5h, A5h, then 5Ah.
- An A5h carried across a pulse.

In each pattern the last 5Ah lands after the edge flag is armed. Whether the pulse at 2P+1 appears therefore shows whether the tracker accepted the key. Each hold-off input is held on its own for several intervals.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int TB_WIDTH = 22,
  parameter int TAP_BASE = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wd_enable,
  input  logic [1:0] interval,
  input  logic       half_rate,
  input  logic       hold_sleep,
  input  logic       hold_dma,
  input  logic       hold_break,
  input  logic       hold_inte,
  input  logic       hold_trace,
  output logic       wdt_reset
);
  localparam logic [7:0] KEY_ARM  = 8'hA5;
  localparam logic [7:0] KEY_FIRE = 8'h5A;

  logic [TB_WIDTH-1:0] cnt;
  logic [1:0]          sel_q;
  logic                phase, en_q, tap_q, armed, key_q, tap;

  wire tick    = ~half_rate | phase;
  wire hold    = hold_sleep | hold_dma | hold_break | hold_inte | hold_trace;
  wire wr_arm  = wr_en && (wr_data == KEY_ARM);
  wire wr_fire = wr_en && (wr_data == KEY_FIRE);
  wire service = wr_fire & key_q;
  wire fall    = tap_q & ~tap;
  wire fire    = en_q & ~hold & ~service & fall & armed;

  always_comb tap = cnt[TAP_BASE + int'(sel_q)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sel_q     <= '0;
      phase     <= 1'b0;
      en_q      <= 1'b0;
      tap_q     <= 1'b0;
      armed     <= 1'b0;
      key_q     <= 1'b0;
      wdt_reset <= 1'b0;
    end else begin
      en_q      <= en_q | wd_enable;
      wdt_reset <= fire;
      if (!en_q) sel_q <= interval;
      if (fire) begin
        cnt   <= '0;
        phase <= 1'b0;
        tap_q <= 1'b0;
        armed <= 1'b0;
        key_q <= 1'b0;
      end else begin
        phase <= half_rate & ~phase;
        if (tick) cnt <= cnt + 1'b1;
        tap_q <= tap;
        if (wr_en) key_q <= wr_arm;
        if (!en_q || hold || service) armed <= 1'b0;
        else if (fall)                armed <= 1'b1;
      end
    end
  end
endmodule

module keyed_watchdog_chk #(
  parameter int TB_WIDTH = 22
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wdt_reset,
  input logic                en_q,
  input logic [1:0]          sel_q,
  input logic                hold,
  input logic                armed,
  input logic [TB_WIDTH-1:0] cnt
);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);
  p_count_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> (cnt == '0 && !armed));
  p_needs_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset) |-> $past(armed));
  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !wdt_reset);
  p_enable_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  p_interval_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(sel_q));
  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !wdt_reset);
  p_hold_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !armed);
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.TB_WIDTH(TB_WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_reset(wdt_reset), .en_q(en_q),
  .sel_q(sel_q), .hold(hold), .armed(armed), .cnt(cnt)
);

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;
  localparam int TBW = 8;
  localparam int TBASE = 2;

  logic clk = 0, rst_n = 0, wr_en = 0, wd_enable = 0, half_rate = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] interval = 0;
  logic [4:0] holds = 0;
  logic wdt_reset;
  int cyc = 0, pulses = 0, last_pulse = 0, checks = 0, fails = 0;
  bit prev_hi = 0;

  always #2 clk = ~clk;

  keyed_watchdog #(.TB_WIDTH(TBW), .TAP_BASE(TBASE)) i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wd_enable(wd_enable), .interval(interval), .half_rate(half_rate),
    .hold_sleep(holds[0]), .hold_dma(holds[1]), .hold_break(holds[2]),
    .hold_inte(holds[3]), .hold_trace(holds[4]), .wdt_reset(wdt_reset));

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (rst_n && wdt_reset) begin
      pulses++;
      last_pulse = cyc;
      checks++;
      if (prev_hi) begin
        fails++;
        $display("FAIL R3 pulse width: actual 2+ expected 1 at cycle %0d", cyc);
      end
    end
    prev_hi = wdt_reset;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int period(input int sel);
    return 1 << (TBASE + sel + 1);
  endfunction

  task automatic restart(input int sel, input bit half, input bit en, output int rel);
    @(negedge clk);
    rst_n = 0; interval = sel[1:0]; half_rate = half; wd_enable = en; holds = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rel = cyc;
  endtask

  task automatic wait_pulse(input int tmo, output bit found);
    int n0 = pulses;
    found = 0;
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (pulses != n0) begin found = 1; break; end
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr_at(input int c, input logic [7:0] b);
    wait_until(c);
    wr_en = 1; wr_data = b;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic sync(output int e);
    bit f;
    wait_pulse(400, f);
    e = last_pulse;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int rel, e, e2, n0, p;
    bit f;
    // reset state
    repeat (2) @(negedge clk);
    check(wdt_reset == 0, "R3 reset state", wdt_reset, 0);

    // R1 R2 R3: timeout sweep
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 4; s++) begin
        p = period(s);
        restart(s, h[0], 1, rel);
        wait_pulse(600, f);
        check(f && last_pulse - rel == (h ? 4*p+1 : 2*p+1), "R1/R2 first timeout",
              last_pulse - rel, h ? 4*p+1 : 2*p+1);
        e = last_pulse;
        wait_pulse(600, f);
        check(f && last_pulse - e == (h ? 4*p+1 : 2*p+1), "R3 repeat timeout",
              last_pulse - e, h ? 4*p+1 : 2*p+1);
      end

    // R4: disabled, then one-way enable
    restart(0, 0, 0, rel);
    n0 = pulses;
    repeat (200) @(negedge clk);
    check(pulses == n0, "R4 disabled no reset", pulses - n0, 0);
    wd_enable = 1; @(negedge clk); wd_enable = 0;
    wait_pulse(40, f);
    check(f, "R4 enable sticky", f, 1);

    // R5: interval locked
    restart(0, 0, 1, rel);
    @(negedge clk); interval = 3;
    wait_pulse(600, f);
    check(f && last_pulse - rel == 17, "R5 interval locked", last_pulse - rel, 17);

    // R6: regular service
    restart(0, 0, 1, rel);
    sync(e);
    n0 = pulses;
    for (int k = 0; k < 30; k++) begin
      wr_at(e + 2 + 6*k, 8'hA5);
      wr_at(e + 6 + 6*k, 8'h5A);
    end
    check(pulses == n0, "R6 regular service", pulses - n0, 0);

    // R6 + R9: A5, A5, long gap, 5A after arm
    sync(e);
    n0 = pulses;
    wr_at(e + 2, 8'hA5); wr_at(e + 5, 8'hA5); wr_at(e + 11, 8'h5A);
    wait_until(e + 20);
    check(pulses == n0, "R9 double A5 then 5A services", pulses - n0, 0);

    // R7: wrong byte cancels
    sync(e);
    wr_at(e + 2, 8'hA5); wr_at(e + 9, 8'h00); wr_at(e + 11, 8'h5A);
    wait_until(e + 20);
    check(last_pulse == e + 17, "R7 wrong byte cancels", last_pulse - e, 17);

    // R8: 5A alone
    e = last_pulse;
    wr_at(e + 11, 8'h5A);
    wait_until(e + 20);
    check(last_pulse == e + 17, "R8 lone 5A ignored", last_pulse - e, 17);

    // R8: two 5A with no A5 between
    e = last_pulse;
    wr_at(e + 2, 8'hA5); wr_at(e + 4, 8'h5A); wr_at(e + 11, 8'h5A);
    wait_until(e + 20);
    check(last_pulse == e + 17, "R8 second 5A needs A5", last_pulse - e, 17);

    // R11: key cleared by pulse
    e = last_pulse;
    wr_at(e + 14, 8'hA5);
    wait_until(e + 20);
    check(last_pulse == e + 17, "R11 pulse after late A5", last_pulse - e, 17);
    e2 = last_pulse;
    wr_at(e2 + 11, 8'h5A);
    wait_until(e2 + 20);
    check(last_pulse == e2 + 17, "R11 key lost at pulse", last_pulse - e2, 17);

    // R10: each hold-off input
    for (int j = 0; j < 5; j++) begin
      sync(e);
      n0 = pulses;
      holds = 5'b1 << j;
      repeat (60) @(negedge clk);
      check(pulses == n0, $sformatf("R10 hold %0d blocks reset", j), pulses - n0, 0);
      holds = 0;
      wait_pulse(30, f);
      check(f, $sformatf("R10 hold %0d release resumes", j), f, 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule